// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an internal request bus and an external asynchronous static RAM of 128K bytes. Each accepted request becomes a complete strobe sequence on the memory pins: a 17-bit address, active-low chip select, write enable and output enable, and an 8-bit bidirectional data bus that the controller tri-states whenever the memory might be driving it. Reads return the byte on `rsp_rdata_o` together with a one-cycle `rsp_done_o` pulse. Writes report completion with the same pulse.

The memory's nanosecond limits are turned into clock counts at elaboration time. The access window, the write pulse and the data setup window each get their own count. Each count is the limit divided by the clock period, rounded up, and never less than 1. A request is taken with a valid/ready handshake. A request is accepted only while the controller is idle: chip select is high and the data bus is released.

Every access starts with one setup cycle. During that cycle chip select is low and both enables are high. This cycle gives bus turnaround in both directions. All strobes come from flops, so no decode glitch reaches the memory pins.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, chip select, write enable and output enable are all high (inactive), `req_ready_o` is 1 and `rsp_done_o` is 0.
- R2: The controller accepts a read when `req_valid_i` and `req_ready_o` are both 1 at a clock edge and `req_we_i` is 0. The memory's byte at `req_addr_i` then appears on `rsp_rdata_o`, with `rsp_done_o` high for one cycle. This happens right after edge 1+READ_CLKS counted from the accept edge, where READ_CLKS = max(1, ceil(T_RC_NS/CLK_PERIOD_NS)). The data stays there until the next read completes.
- R3: An accepted request with `req_we_i` = 1 stores `req_wdata_i` at `req_addr_i`. `rsp_done_o` pulses right after edge 2+PULSE counted from the accept edge. PULSE = max(WE_PULSE_CLKS, DATA_SETUP_CLKS), and each of those two counts is ceil(ns / period) with a minimum of 1.
- R4: Output enable and write enable are never low together. Output enable stays high for the whole of a write.
- R5: Each write-enable low pulse lasts exactly PULSE clock cycles. Chip select is low for the whole pulse, so write enable ends the write.
- R6: The address pins do not change while chip select stays low across consecutive cycles.
- R7: `req_ready_o` is 1 only while chip select is high. While `req_valid_i` is 0, the memory stays deselected. While a request is in progress, `req_ready_o` is 0.
- R8: `rsp_done_o` is never high for two cycles in a row. The controller drives the write data on the bus from the falling edge of write enable until one cycle after its rising edge.
- R9: The controller drives the data bus only while output enable is high. A falling output enable is always preceded by a cycle in which chip select is low and write enable is high. The controller starts driving only after output enable has been high for a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Read data, valid with the done pulse |
| sram_addr_o | output | 17 | Memory address pins |
| sram_cs_no | output | 1 | Memory chip select, active low |
| sram_we_no | output | 1 | Memory write enable, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_data_io | inout | 8 | Memory data bus, tri-stated by the controller |

## Verification
Results are due at fixed points after the accept edge. A read completes exactly 1+READ_CLKS edges later (3 at the defaults), and a write completes 2+PULSE edges later (4 at the defaults). The bench counts falling clock edges from the accept edge and checks the latency and the data together in the first cycle in which `rsp_done_o` is high. The bench holds a behavioural memory that latches the bus on the rising edge of write enable and drives the bus only while output enable is low. Each write-enable pulse is measured in cycles at falling clock edges, and the readiness and deselect checks are made on falling edges while requests are in progress or absent.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_ACCESS,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } ctrl_state_e;

  // ceil(ns / period), never below one clock
  function automatic int clk_count(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_io.sv
module sram_ctrl_io #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          drive_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          capture_i,
  input  logic          oe_n_i,
  output logic [DW-1:0] rdata_o,
  inout  wire  [DW-1:0] data_io
);

  logic [DW-1:0] rdata_q;

  assign data_io = drive_en_i ? wdata_i : {DW{1'bz}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= data_io;
  end

  assign rdata_o = rdata_q;

  AST_NO_CONTEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_en_i |-> oe_n_i); // R9
  AST_DRIVE_AFTER_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_en_i) |-> $past(oe_n_i)); // R9

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 15,
  parameter int T_WP_NS       = 12,
  parameter int T_DW_NS       = 8,
  parameter int AW            = 17,
  parameter int DW            = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_done_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_cs_no,
  output logic          sram_we_no,
  output logic          sram_oe_no,
  inout  wire  [DW-1:0] sram_data_io
);

  localparam int READ_CLKS       = clk_count(T_RC_NS, CLK_PERIOD_NS);
  localparam int WE_PULSE_CLKS   = clk_count(T_WP_NS, CLK_PERIOD_NS);
  localparam int DATA_SETUP_CLKS = clk_count(T_DW_NS, CLK_PERIOD_NS);
  // data is driven from the start of the pulse, so setup is covered by the pulse
  localparam int PULSE_CLKS      = max_int(WE_PULSE_CLKS, DATA_SETUP_CLKS);
  localparam int MAX_CLKS        = max_int(READ_CLKS, PULSE_CLKS);
  localparam int CW              = $clog2(MAX_CLKS + 1);

  ctrl_state_e   state_q, state_d;
  logic          tmr_load, tmr_zero, capture;
  logic [CW-1:0] tmr_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          cs_n_q, we_n_q, oe_n_q, drive_q, done_q;
  logic          accept;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE:      if (req_valid_i) state_d = req_we_i ? ST_WR_SETUP : ST_RD_SETUP;
      ST_RD_SETUP: begin
        tmr_load = 1'b1;
        tmr_val  = CW'(READ_CLKS - 1);
        state_d  = ST_RD_ACCESS;
      end
      ST_RD_ACCESS: if (tmr_zero) begin
        capture = 1'b1;
        state_d = ST_IDLE;
      end
      ST_WR_SETUP: begin
        tmr_load = 1'b1;
        tmr_val  = CW'(PULSE_CLKS - 1);
        state_d  = ST_WR_PULSE;
      end
      ST_WR_PULSE:  if (tmr_zero) state_d = ST_WR_HOLD;
      ST_WR_HOLD:   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      drive_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      // strobes registered from next state: glitch-free at the pins
      cs_n_q  <= (state_d == ST_IDLE);
      oe_n_q  <= (state_d != ST_RD_ACCESS);
      we_n_q  <= (state_d != ST_WR_PULSE);
      drive_q <= (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
      done_q  <= capture || (state_q == ST_WR_HOLD);
    end
  end

  sram_ctrl_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sram_ctrl_io #(.DW(DW)) u_io (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .drive_en_i (drive_q),
    .wdata_i    (wdata_q),
    .capture_i  (capture),
    .oe_n_i     (oe_n_q),
    .rdata_o    (rsp_rdata_o),
    .data_io    (sram_data_io)
  );

  assign sram_addr_o = addr_q;
  assign sram_cs_no  = cs_n_q;
  assign sram_we_no  = we_n_q;
  assign sram_oe_no  = oe_n_q;
  assign rsp_done_o  = done_q;

  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_no && !sram_we_no)); // R4
  AST_WE_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> !sram_cs_no); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_cs_no && $past(!sram_cs_no)) |-> $stable(sram_addr_o)); // R6
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> sram_cs_no); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o); // R8
  AST_WE_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> drive_q); // R8
  AST_OE_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_oe_no) |-> $past(!sram_cs_no && sram_we_no)); // R9

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int DW = 8;
  // expected counts from the timing limits: ceil(15/10), ceil(12/10), ceil(8/10)
  localparam int EXP_READ  = 2;
  localparam int EXP_PULSE = 2;
  localparam int RD_LAT    = 1 + EXP_READ;
  localparam int WR_LAT    = 2 + EXP_PULSE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_cs_n, sram_we_n, sram_oe_n;
  wire  [DW-1:0] sram_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] expv [256];
  int            we_low = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_we_i     (req_we),
    .req_addr_i   (req_addr),
    .req_wdata_i  (req_wdata),
    .rsp_done_o   (rsp_done),
    .rsp_rdata_o  (rsp_rdata),
    .sram_addr_o  (sram_addr),
    .sram_cs_no   (sram_cs_n),
    .sram_we_no   (sram_we_n),
    .sram_oe_no   (sram_oe_n),
    .sram_data_io (sram_data)
  );

  // memory model: drives only while selected, output-enabled and not writing
  assign sram_data = (!sram_cs_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[7:0]] : {DW{1'bz}};

  always @(posedge sram_we_n) begin
    if (rst_n && !sram_cs_n) mem[sram_addr[7:0]] = sram_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R5: width of every write-enable pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (!sram_we_n) we_low++;
      else if (we_low != 0) begin
        chk(we_low == EXP_PULSE, "R5 we pulse width", we_low, EXP_PULSE);
        we_low = 0;
      end
    end
  end

  task automatic do_req(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int lat, output logic [DW-1:0] rd);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    chk(req_ready == 1'b0, "R7 ready low while busy", int'(req_ready), 0);
    while (!rsp_done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
  endtask

  function automatic logic [AW-1:0] addr_of(input int i);
    logic [8:0] hi;
    hi = 9'((i * 7) & 9'h1FF);
    return {hi, 8'(i)};
  endfunction

  initial begin
    int lat;
    logic [DW-1:0] rd;
    repeat (3) @(negedge clk);
    chk(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes high in reset",
        int'({sram_cs_n, sram_we_n, sram_oe_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(rsp_done == 1'b0, "R1 done low after reset", int'(rsp_done), 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(sram_cs_n == 1'b1, "R7 deselected with no request", int'(sram_cs_n), 1);
    end

    // R3: write sweep
    for (int i = 0; i < 256; i++) begin
      expv[i] = 8'((i * 37 + 11) & 8'hFF);
      do_req(1'b1, addr_of(i), expv[i], lat, rd);
      chk(lat == WR_LAT, "R3 write latency", lat, WR_LAT);
      chk(mem[i] == expv[i], "R3 stored byte", int'(mem[i]), int'(expv[i]));
      @(negedge clk);
      chk(rsp_done == 1'b0, "R8 done single cycle", int'(rsp_done), 0);
    end

    // R2: read sweep
    for (int i = 0; i < 256; i++) begin
      do_req(1'b0, addr_of(i), 8'h00, lat, rd);
      chk(lat == RD_LAT, "R2 read latency", lat, RD_LAT);
      chk(rd == expv[i], "R2 read data", int'(rd), int'(expv[i]));
      @(negedge clk);
      chk(rsp_rdata == expv[i], "R2 read data held", int'(rsp_rdata), int'(expv[i]));
    end

    // R3: overwrite with inverted data, then read back
    for (int i = 0; i < 256; i += 17) begin
      expv[i] = ~expv[i];
      do_req(1'b1, addr_of(i), expv[i], lat, rd);
      do_req(1'b0, addr_of(i), 8'h00, lat, rd);
      chk(rd == expv[i], "R3 overwrite read back", int'(rd), int'(expv[i]));
    end

    repeat (4) @(negedge clk);
    chk(sram_cs_n && sram_oe_n && sram_we_n, "R7 idle after traffic",
        int'({sram_cs_n, sram_we_n, sram_oe_n}), 7);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

endmodule